// File: doc/BRIEF.md
# CDR Lock and Link-Fault Supervisor

This block is the digital supervisor of a clock-recovery loop. Running on the reference clock, it receives, on each reference cycle, the number of recovered-clock edges seen in that cycle. It accumulates them over a fixed gate window of reference cycles and compares the total with the count the selected reference multiplier predicts. From that comparison it decides whether the recovery loop is locked to the incoming data or has to stay in training on the multiplied reference. It also drives the link-fault indicator and gates the serial data. It raises a configuration error for a multiplier/rate pairing that is not allowed. It registers which clock feeds the transmit clock output.

The carrier-detect input goes through a two-flop synchronizer before use. While carrier is absent, the block holds the loop in training, forces the data and link-fault outputs low, and clears all qualification history. After carrier returns, and after any drop out of lock, an acquisition hold of a set number of reference cycles runs before the first gate window starts. Lock requires two good windows in a row. One bad window releases lock.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While the synchronized carrier is high, `sdat_o` equals `sdat_i` delayed by one reference cycle.
- R2: When `cd_i` stays low, `locked_o`, `lfi_o` and `sdat_o` are all low within three reference edges and stay low. The loop stays in training however `sdat_i` toggles.
- R3: `lfi_o` is high only when the carrier is present and the loop was locked on the previous cycle. It falls together with lock loss, give or take one cycle.
- R4: A window counts as good when |edges counted − multiplier·2^WIN_LOG2| ≤ (multiplier·2^WIN_LOG2) >> TOL_SHIFT, both boundaries included. Lock is declared only after two consecutive good windows.
- R5: While locked, a single bad window clears `locked_o` and restarts the acquisition hold.
- R6: The multiplier code `mult_sel_i` maps as 000→×1, 001→×2, 010→×4, 011→×32, 100→×8, 101→×10, 110→×16, 111→×20.
- R7: Code 011 on `mult_sel_i` with `rate_sel_i` ≠ 000 sets `cfg_err_o` one cycle later and holds training. Code 011 with `rate_sel_i` = 000 is legal.
- R8: `txsrc_o` is `clksel_i` registered once: 1 selects the recovered clock, 0 selects the synthesizer clock.
- R9: After carrier is established, and after every return to training, no window is evaluated until ACQ_CYC reference cycles have passed.
- R10: In reset, `locked_o`, `lfi_o`, `sdat_o`, `txsrc_o` and `cfg_err_o` are low.
- R11: The outputs do not respond to a `cd_i` change before the second reference edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rec_edges_i | input | EDGE_W | Recovered-clock edges seen in this reference cycle |
| cd_i | input | 1 | Carrier detect, asynchronous |
| sdat_i | input | 1 | Serial data sampled by the recovery path |
| mult_sel_i | input | 3 | Reference multiplier code |
| rate_sel_i | input | 3 | Output rate (VCO divide) code |
| clksel_i | input | 1 | Transmit clock source request |
| locked_o | output | 1 | 1 = locked to data, 0 = training on reference |
| lfi_o | output | 1 | Link-fault indicator, high when link is good |
| cfg_err_o | output | 1 | Illegal multiplier/rate pairing |
| sdat_o | output | 1 | Carrier-gated serial data |
| txsrc_o | output | 1 | Transmit clock source select |

## Verification
`sdat_o`, `txsrc_o` and `cfg_err_o` follow their inputs one edge later, so the bench drives on a falling edge and reads on the next one. Carrier loss passes through two synchronizer flops and one state flop. The bench therefore reads one falling edge after the drop and expects no change, then reads three edges after it and expects everything low. Lock takes the synchronizer, the acquisition hold and two full windows. The bench reads at ACQ_CYC plus one and a half windows, where lock must still be absent, and again at ACQ_CYC plus three windows, where the final state has settled. The edge patterns are periodic with periods that divide the window, so every window holds the same count wherever it starts.

// File: rtl/cdr_lock_pkg.sv
`timescale 1ns/1ps
package cdr_lock_pkg;

    localparam int SEL_W  = 3;
    localparam int MULT_W = 6;

    typedef enum logic {
        TX_SYNTH = 1'b0,
        TX_RECOV = 1'b1
    } tx_src_e;

    // Reference multiplier selected by the code; order of codes is fixed by the pin map.
    function automatic logic [MULT_W-1:0] mult_of(input logic [SEL_W-1:0] code);
        logic [MULT_W-1:0] m;
        case (code)
            3'b000:  m = 6'd1;
            3'b001:  m = 6'd2;
            3'b010:  m = 6'd4;
            3'b011:  m = 6'd32;
            3'b100:  m = 6'd8;
            3'b101:  m = 6'd10;
            3'b110:  m = 6'd16;
            default: m = 6'd20;
        endcase
        return m;
    endfunction

    // x32 is only usable at the undivided VCO rate.
    function automatic logic pair_illegal(input logic [SEL_W-1:0] msel,
                                          input logic [SEL_W-1:0] rsel);
        return (msel == 3'b011) && (rsel != 3'b000);
    endfunction

endpackage

// File: rtl/cdr_cfg_decode.sv
`timescale 1ns/1ps
module cdr_cfg_decode
    import cdr_lock_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [SEL_W-1:0]  msel_i,
    input  logic [SEL_W-1:0]  rsel_i,
    output logic [MULT_W-1:0] mult_o,
    output logic              err_o
);

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic              err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.mult = mult_of(msel_i);
        cfg_d.err  = pair_illegal(msel_i, rsel_i);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cfg_q <= '{mult: MULT_W'(1), err: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mult_o = cfg_q.mult;
    assign err_o  = cfg_q.err;

endmodule

// File: rtl/cdr_cd_sync.sv
`timescale 1ns/1ps
module cdr_cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cdr_freq_window.sv
`timescale 1ns/1ps
module cdr_freq_window
    import cdr_lock_pkg::*;
#(
    parameter int WIN_LOG2  = 14,
    parameter int TOL_SHIFT = 10,
    parameter int EDGE_W    = 6
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              run_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [EDGE_W-1:0] edges_i,
    output logic              done_o,
    output logic              good_o
);

    localparam int CNT_W = WIN_LOG2 + EDGE_W + 1;

    typedef struct packed {
        logic [WIN_LOG2-1:0] ref_cnt;
        logic [CNT_W-1:0]    acc;
        logic                done;
        logic                good;
    } win_t;

    win_t win_d, win_q;

    logic [CNT_W-1:0] sum;
    logic [CNT_W-1:0] expct;
    logic [CNT_W-1:0] tol;
    logic [CNT_W-1:0] diff;

    always_comb begin
        sum   = win_q.acc + CNT_W'(edges_i);
        expct = CNT_W'(mult_i) << WIN_LOG2;
        tol   = expct >> TOL_SHIFT;
        diff  = (sum >= expct) ? (sum - expct) : (expct - sum);

        win_d      = win_q;
        win_d.done = 1'b0;
        win_d.good = 1'b0;
        if (!run_i) begin
            win_d.ref_cnt = '0;
            win_d.acc     = '0;
        end else if (&win_q.ref_cnt) begin
            win_d.ref_cnt = '0;
            win_d.acc     = '0;
            win_d.done    = 1'b1;
            win_d.good    = (diff <= tol);
        end else begin
            win_d.ref_cnt = win_q.ref_cnt + 1'b1;
            win_d.acc     = sum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign done_o = win_q.done;
    assign good_o = win_q.good;

endmodule

// File: rtl/cdr_lock_ctrl.sv
`timescale 1ns/1ps
module cdr_lock_ctrl
    import cdr_lock_pkg::*;
#(
    parameter int WIN_LOG2  = 14,
    parameter int TOL_SHIFT = 10,
    parameter int ACQ_CYC   = 2400,
    parameter int EDGE_W    = 6
) (
    input  logic              clk_ref_i,
    input  logic              rst_n_i,
    input  logic [EDGE_W-1:0] rec_edges_i,
    input  logic              cd_i,
    input  logic              sdat_i,
    input  logic [SEL_W-1:0]  mult_sel_i,
    input  logic [SEL_W-1:0]  rate_sel_i,
    input  logic              clksel_i,
    output logic              locked_o,
    output logic              lfi_o,
    output logic              cfg_err_o,
    output logic              sdat_o,
    output logic              txsrc_o
);

    localparam int ACQ_W = $clog2(ACQ_CYC + 1);

    typedef struct packed {
        logic             locked;
        logic             good_seen;
        logic [ACQ_W-1:0] acq;
        logic             lfi;
        logic             sdat;
        tx_src_e          txsrc;
    } st_t;

    st_t st_d, st_q;

    logic              carrier;
    logic [MULT_W-1:0] mult;
    logic              cfg_err;
    logic              acq_done;
    logic              win_run;
    logic              win_done;
    logic              win_good;

    cdr_cd_sync #(.STAGES(2)) u_cd_sync (
        .clk_i   (clk_ref_i),
        .rst_n_i (rst_n_i),
        .async_i (cd_i),
        .sync_o  (carrier)
    );

    cdr_cfg_decode u_cfg (
        .clk_i   (clk_ref_i),
        .rst_n_i (rst_n_i),
        .msel_i  (mult_sel_i),
        .rsel_i  (rate_sel_i),
        .mult_o  (mult),
        .err_o   (cfg_err)
    );

    assign acq_done = (st_q.acq == ACQ_W'(ACQ_CYC));
    assign win_run  = carrier && !cfg_err && acq_done;

    cdr_freq_window #(
        .WIN_LOG2  (WIN_LOG2),
        .TOL_SHIFT (TOL_SHIFT),
        .EDGE_W    (EDGE_W)
    ) u_win (
        .clk_i   (clk_ref_i),
        .rst_n_i (rst_n_i),
        .run_i   (win_run),
        .mult_i  (mult),
        .edges_i (rec_edges_i),
        .done_o  (win_done),
        .good_o  (win_good)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sdat  = carrier & sdat_i;
        st_d.txsrc = clksel_i ? TX_RECOV : TX_SYNTH;
        st_d.lfi   = carrier && st_q.locked && !cfg_err;

        if (!carrier || cfg_err) begin
            st_d.locked    = 1'b0;
            st_d.good_seen = 1'b0;
            st_d.acq       = '0;
        end else if (!acq_done) begin
            st_d.acq = st_q.acq + 1'b1;
        end else if (win_done) begin
            if (win_good) begin
                if (!st_q.locked) begin
                    if (st_q.good_seen) begin
                        st_d.locked    = 1'b1;
                        st_d.good_seen = 1'b0;
                    end else begin
                        st_d.good_seen = 1'b1;
                    end
                end
            end else begin
                st_d.locked    = 1'b0;
                st_d.good_seen = 1'b0;
                st_d.acq       = '0;
            end
        end
    end

    always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '{locked: 1'b0, good_seen: 1'b0, acq: '0,
                      lfi: 1'b0, sdat: 1'b0, txsrc: TX_SYNTH};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o  = st_q.locked;
    assign lfi_o     = st_q.lfi;
    assign cfg_err_o = cfg_err;
    assign sdat_o    = st_q.sdat;
    assign txsrc_o   = st_q.txsrc;

endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
`timescale 1ns/1ps
module cdr_lock_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cd_i,
    input logic sdat_i,
    input logic clksel_i,
    input logic locked_o,
    input logic lfi_o,
    input logic cfg_err_o,
    input logic sdat_o,
    input logic txsrc_o,
    input logic win_done,
    input logic win_good
);

    AST_SDAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sdat_o) |-> $past(sdat_i)); // R1

    AST_CARRIER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_i && !$past(cd_i) && !$past(cd_i, 2)) |=> (!locked_o && !lfi_o && !sdat_o)); // R2

    AST_FAULT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lfi_o |-> $past(locked_o)); // R3

    AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(win_done && win_good)); // R4

    AST_BAD_WINDOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_good) |=> !locked_o); // R5

    AST_CFG_HOLDS_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && $past(cfg_err_o)) |-> !locked_o); // R7

    AST_TXSRC_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (txsrc_o == $past(clksel_i))); // R8

endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
    .clk       (clk_ref_i),
    .rst_n     (rst_n_i),
    .cd_i      (cd_i),
    .sdat_i    (sdat_i),
    .clksel_i  (clksel_i),
    .locked_o  (locked_o),
    .lfi_o     (lfi_o),
    .cfg_err_o (cfg_err_o),
    .sdat_o    (sdat_o),
    .txsrc_o   (txsrc_o),
    .win_done  (win_done),
    .win_good  (win_good)
);

// File: tb/test_cdr_lock_ctrl.sv
`timescale 1ns/1ps
module test_cdr_lock_ctrl;

    localparam int WIN_LOG2  = 8;
    localparam int WIN       = 1 << WIN_LOG2;
    localparam int TOL_SHIFT = 4;
    localparam int ACQ_CYC   = 300;
    localparam int EDGE_W    = 6;

    typedef struct packed {
        logic [2:0] msel;
        logic [2:0] rsel;
        int         base;
        int         per;
        int         dlt;
        int         xtra;
        logic       exp_lock;
        logic       exp_err;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{3'b000, 3'b000,  1,  1,  0,  0, 1'b1, 1'b0},  // x1 exact
        '{3'b000, 3'b000,  1, 16,  1,  0, 1'b1, 1'b0},  // +tol boundary
        '{3'b000, 3'b000,  1, 16,  1,  1, 1'b0, 1'b0},  // +tol+1
        '{3'b000, 3'b000,  1, 16, -1,  0, 1'b1, 1'b0},  // -tol boundary
        '{3'b000, 3'b000,  1, 16, -1, -1, 1'b0, 1'b0},  // -tol-1
        '{3'b001, 3'b000,  2,  1,  0,  0, 1'b1, 1'b0},  // x2
        '{3'b001, 3'b000,  1,  1,  0,  0, 1'b0, 1'b0},  // half rate for x2
        '{3'b010, 3'b000,  4,  1,  0,  0, 1'b1, 1'b0},  // x4
        '{3'b011, 3'b000, 32,  1,  0,  0, 1'b1, 1'b0},  // x32 legal
        '{3'b011, 3'b010, 32,  1,  0,  0, 1'b0, 1'b1},  // x32 illegal pairing
        '{3'b100, 3'b000,  8,  2,  1,  0, 1'b1, 1'b0},  // x8 at +tol
        '{3'b101, 3'b000, 10,  1,  0,  0, 1'b1, 1'b0},  // x10
        '{3'b110, 3'b000, 20,  1,  0,  0, 1'b0, 1'b0},  // x16 given x20 rate
        '{3'b111, 3'b000, 20,  1,  0,  0, 1'b1, 1'b0}   // x20
    };

    logic              clk_ref_i = 1'b0;
    logic              rst_n_i = 1'b0;
    logic [EDGE_W-1:0] rec_edges_i = '0;
    logic              cd_i = 1'b0;
    logic              sdat_i = 1'b0;
    logic [2:0]        mult_sel_i = 3'b000;
    logic [2:0]        rate_sel_i = 3'b000;
    logic              clksel_i = 1'b0;
    logic              locked_o, lfi_o, cfg_err_o, sdat_o, txsrc_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int g_base = 1, g_per = 1, g_dlt = 0, g_xtra = 0;
    bit done_flag = 1'b0;

    always #10 clk_ref_i = ~clk_ref_i;

    cdr_lock_ctrl #(
        .WIN_LOG2 (WIN_LOG2), .TOL_SHIFT (TOL_SHIFT),
        .ACQ_CYC (ACQ_CYC), .EDGE_W (EDGE_W)
    ) i_cdr_lock_ctrl (
        .clk_ref_i (clk_ref_i), .rst_n_i (rst_n_i), .rec_edges_i (rec_edges_i),
        .cd_i (cd_i), .sdat_i (sdat_i), .mult_sel_i (mult_sel_i),
        .rate_sel_i (rate_sel_i), .clksel_i (clksel_i), .locked_o (locked_o),
        .lfi_o (lfi_o), .cfg_err_o (cfg_err_o), .sdat_o (sdat_o), .txsrc_o (txsrc_o)
    );

    // Edge pattern: periods divide the window, so every window sees the same total.
    always @(negedge clk_ref_i) begin
        int v;
        cyc <= cyc + 1;
        v = g_base + (((cyc % g_per) == 0) ? g_dlt : 0) + (((cyc % 256) == 8) ? g_xtra : 0);
        rec_edges_i <= EDGE_W'(v);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk_ref_i);
    endtask

    task automatic set_pat(input int b, input int p, input int d, input int x);
        g_base = b; g_per = p; g_dlt = d; g_xtra = x;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        wait_n(3);
        check(locked_o == 1'b0, "R10 locked in reset", int'(locked_o), 0);
        check(lfi_o == 1'b0, "R10 lfi in reset", int'(lfi_o), 0);
        check(sdat_o == 1'b0, "R10 sdat in reset", int'(sdat_o), 0);
        check(txsrc_o == 1'b0, "R10 txsrc in reset", int'(txsrc_o), 0);
        check(cfg_err_o == 1'b0, "R10 cfg_err in reset", int'(cfg_err_o), 0);
        rst_n_i = 1'b1;
        wait_n(2);

        // Table walk: R4 R6 R7 R9 R3
        for (int i = 0; i < NVEC; i++) begin
            cd_i = 1'b0;
            mult_sel_i = VEC[i].msel;
            rate_sel_i = VEC[i].rsel;
            set_pat(VEC[i].base, VEC[i].per, VEC[i].dlt, VEC[i].xtra);
            wait_n(5);
            cd_i = 1'b1;
            wait_n(ACQ_CYC + WIN + WIN / 2);
            check(locked_o == 1'b0, "R9 R4 lock before hold plus two windows", int'(locked_o), 0);
            check(cfg_err_o == VEC[i].exp_err, "R7 cfg_err", int'(cfg_err_o), int'(VEC[i].exp_err));
            wait_n(WIN + WIN / 2 + 20);
            check(locked_o == VEC[i].exp_lock, "R4 R6 lock verdict", int'(locked_o), int'(VEC[i].exp_lock));
            check(lfi_o == VEC[i].exp_lock, "R3 lfi", int'(lfi_o), int'(VEC[i].exp_lock));
        end

        // R1: data passes with one cycle latency (last vector left locked, carrier high)
        for (int k = 0; k < 6; k++) begin
            bit b;
            b = (k % 3) != 1;
            sdat_i = b;
            wait_n(1);
            check(sdat_o == b, "R1 data pass", int'(sdat_o), int'(b));
        end

        // R11 / R2: carrier loss
        sdat_i = 1'b1;
        cd_i = 1'b0;
        wait_n(1);
        check(locked_o == 1'b1, "R11 no early response", int'(locked_o), 1);
        check(sdat_o == 1'b1, "R11 sdat not yet gated", int'(sdat_o), 1);
        wait_n(2);
        check(locked_o == 1'b0, "R2 lock cleared", int'(locked_o), 0);
        check(lfi_o == 1'b0, "R2 lfi cleared", int'(lfi_o), 0);
        check(sdat_o == 1'b0, "R2 data forced low", int'(sdat_o), 0);
        for (int k = 0; k < 4; k++) begin
            sdat_i = k[0];
            wait_n(1);
            check(sdat_o == 1'b0, "R2 data stays low", int'(sdat_o), 0);
        end
        wait_n(2 * WIN);
        check(locked_o == 1'b0, "R2 training held", int'(locked_o), 0);

        // R8: transmit clock source
        clksel_i = 1'b1;
        wait_n(1);
        check(txsrc_o == 1'b1, "R8 recovered source", int'(txsrc_o), 1);
        clksel_i = 1'b0;
        wait_n(1);
        check(txsrc_o == 1'b0, "R8 synthesizer source", int'(txsrc_o), 0);

        // R5: one bad window drops lock
        sdat_i = 1'b0;
        mult_sel_i = 3'b000;
        rate_sel_i = 3'b000;
        set_pat(1, 1, 0, 0);
        cd_i = 1'b1;
        wait_n(ACQ_CYC + 3 * WIN + 20);
        check(locked_o == 1'b1, "R4 relock", int'(locked_o), 1);
        set_pat(1, 8, 1, 0);
        wait_n(2 * WIN + 10);
        check(locked_o == 1'b0, "R5 drop after one bad window", int'(locked_o), 0);
        check(lfi_o == 1'b0, "R3 lfi follows drop", int'(lfi_o), 0);

        done_flag = 1'b1;
        finish_run();
    end

endmodule